// File: doc/BRIEF.md
# Shifted Raster-Op Blit Word Datapath

This block is the word-level datapath of a one-bit-per-pixel block-transfer engine built on 16-bit words. An address generator upstream streams pairs of words into it: a source word and the destination word that currently sits at the target location. The block does four things to each pair. It lines the source pixels up with the destination pixel grid through a funnel shift that draws on the previously seen source word. It can replace the source with a constant or with one replicated pixel. It merges source and destination through one of sixteen two-input logic functions. It restricts the write to the pixels of the row by applying edge masks to the first and last word of each row.

Settings arrive through a byte-wide write port with a 3-bit register select. The upstream generator chooses the copy direction: ascending when the destination row is at or above the source row, descending otherwise. It marks the first and last word of every row. The block decides by itself whether the first word of a row is only a priming read. A priming read fills the holding register and produces no output. Each output word comes with the per-pixel write enable that was applied to it. The merged word keeps the old destination value wherever that enable is low.

Top module: `blit_word_path`

## Requirements
- R1: The raster code selects the result per bit from S (source) and D (destination): 0 zero, 1 S&D, 2 S&~D, 3 S, 4 ~S&D, 5 D, 6 S^D, 7 S|D, 8 ~(S|D), 9 ~(S^D), A ~D, B S|~D, C ~S, D ~S|D, E ~(S&D), F one.
- R2: After reset the output is empty, the input is ready, the raster code is 3, the mode is normal (code 111), the source select is plane data, the direction is ascending and all offsets are zero.
- R3: Config writes: select 0 takes the mode in bits [7:5] and the shift in bits [4:0], of which only the low 4 bits are kept (modulo 16). Select 1 takes the raster code in bits [3:0]. Select 2 takes the source select in bits [7:6] and the direction in bit 0 (1 = descending). Select 3 takes the start pixel offset in [7:4] and the end pixel offset in [3:0]. Select 4 takes the source pixel offset in [3:0].
- R4: Ascending alignment with shift s: the aligned source is bits [15+s:s] of {previous, current}. Pixel 0 of a word is bit 15.
- R5: Descending alignment with shift s: the aligned source is bits [31-s:16-s] of {current, previous}.
- R6: On the word flagged as start of row, the previous word is taken as zero. Every accepted word becomes the previous word for the next one.
- R7: In an aligning mode, the start-of-row word is a priming read when the start offset is below the source offset (ascending) or above it (descending). A priming word produces no output, and the next word counts as the first word of the row.
- R8: Source select 00 forces all ones, 01 replicates bit 0 of the incoming source word, and 11 or 10 use the aligned plane word.
- R9: Ascending edge masks: the first word enables bits 15-start..0, and the last word enables bits 15..15-end.
- R10: Descending edge masks: the first word enables bits 15..15-start, and the last word enables bits 15-end..0. A word that is both first and last gets the AND of both masks. Interior words are fully enabled.
- R11: Output bits whose enable is low equal the destination input; enabled bits carry the raster result.
- R12: An accepted non-priming word appears at the output in the next cycle. A stalled output holds its data and mask, and the input is not ready while it is stalled.
- R13: Only modes 100 (blit) and 010 (vector) apply shift, priming and edge masks. Every other mode code passes the source unshifted under a full mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Config byte write strobe |
| cfg_addr | input | 3 | Config register select |
| cfg_wdata | input | 8 | Config byte |
| in_valid | input | 1 | Input word pair valid |
| in_ready | output | 1 | Input word pair accepted when high with in_valid |
| in_src | input | 16 | Source word |
| in_dst | input | 16 | Current destination word |
| in_sol | input | 1 | Word is the first fetched in its row |
| in_eol | input | 1 | Word is the last in its row |
| out_valid | output | 1 | Result word valid |
| out_ready | input | 1 | Downstream takes the result |
| out_data | output | 16 | Merged word to write back |
| out_mask | output | 16 | Per-pixel write enable applied to the word |

## Verification
Every non-priming word that crosses the input handshake owes its result exactly one cycle later. The scoreboard stamps each expected entry with that due cycle, and the monitor checks the cycle in which the word first shows valid. When the output is stalled, the monitor checks that the word stays unchanged until the downstream takes it. Priming words push no entry, so any word output for them would show up as an unexpected result. Outputs are sampled on the falling edge, half a period away from the edge that updates them.

// File: rtl/blit_pkg.sv
package blit_pkg;

    localparam int WORD_W   = 16;
    localparam int OFF_W    = $clog2(WORD_W);
    localparam int ROP_W    = 4;
    localparam int CFG_AW   = 3;
    localparam int CFG_DW   = 8;
    localparam int MODE_W   = 3;

    localparam logic [CFG_AW-1:0] CFG_A_MODE = 3'd0;
    localparam logic [CFG_AW-1:0] CFG_A_ROP  = 3'd1;
    localparam logic [CFG_AW-1:0] CFG_A_SRC  = 3'd2;
    localparam logic [CFG_AW-1:0] CFG_A_EDGE = 3'd3;
    localparam logic [CFG_AW-1:0] CFG_A_SOFF = 3'd4;

    localparam logic [MODE_W-1:0] MODE_VECTOR = 3'b010;
    localparam logic [MODE_W-1:0] MODE_BLIT   = 3'b100;
    localparam logic [MODE_W-1:0] MODE_NORMAL = 3'b111;

    localparam logic [ROP_W-1:0]  ROP_COPY    = 4'h3;

    typedef enum logic [1:0] {
        SRC_ONES  = 2'b00,
        SRC_PIXEL = 2'b01,
        SRC_ALT   = 2'b10,
        SRC_PLANE = 2'b11
    } src_sel_e;

    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic [OFF_W-1:0]  shift;
        logic [ROP_W-1:0]  rop;
        src_sel_e          sel;
        logic              desc;
        logic [OFF_W-1:0]  start_off;
        logic [OFF_W-1:0]  end_off;
        logic [OFF_W-1:0]  src_off;
    } cfg_t;

    localparam cfg_t CFG_RESET = '{
        mode:      MODE_NORMAL,
        shift:     '0,
        rop:       ROP_COPY,
        sel:       SRC_PLANE,
        desc:      1'b0,
        start_off: '0,
        end_off:   '0,
        src_off:   '0
    };

    function automatic logic is_align_mode(input logic [MODE_W-1:0] m);
        return (m == MODE_BLIT) || (m == MODE_VECTOR);
    endfunction

endpackage

// File: rtl/blit_cfg_regs.sv
module blit_cfg_regs
    import blit_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [CFG_AW-1:0] addr,
    input  logic [CFG_DW-1:0] wdata,
    output cfg_t              cfg
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= CFG_RESET;
        end else if (we) begin
            case (addr)
                CFG_A_MODE: begin
                    cfg.mode  <= wdata[7:5];
                    cfg.shift <= wdata[OFF_W-1:0];
                end
                CFG_A_ROP:  cfg.rop <= wdata[ROP_W-1:0];
                CFG_A_SRC: begin
                    cfg.sel  <= src_sel_e'(wdata[7:6]);
                    cfg.desc <= wdata[0];
                end
                CFG_A_EDGE: begin
                    cfg.start_off <= wdata[7:4];
                    cfg.end_off   <= wdata[OFF_W-1:0];
                end
                CFG_A_SOFF: cfg.src_off <= wdata[OFF_W-1:0];
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/blit_align.sv
module blit_align
    import blit_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              acc,
    input  cfg_t              cfg,
    input  logic [WORD_W-1:0] src,
    input  logic              sol,
    output logic [WORD_W-1:0] s_word,
    output logic              prime,
    output logic              first,
    output logic              align_en
);

    localparam int CAT_W = 2 * WORD_W;

    logic [WORD_W-1:0] hold_q;
    logic              pend_q;
    logic [WORD_W-1:0] prev;
    logic [OFF_W-1:0]  sh;
    logic [OFF_W:0]    dn_base;
    logic [CAT_W-1:0]  cat_up;
    logic [CAT_W-1:0]  cat_dn;
    logic [WORD_W-1:0] win;

    assign align_en = is_align_mode(cfg.mode);
    assign sh       = align_en ? cfg.shift : '0;
    assign prev     = sol ? '0 : hold_q;

    // priming read: destination starts left of source (up) or right of it (down)
    assign prime = sol & align_en &
                   (cfg.desc ? (cfg.start_off > cfg.src_off)
                             : (cfg.start_off < cfg.src_off));
    assign first = (sol | pend_q) & ~prime;

    assign cat_up  = {prev, src};
    assign cat_dn  = {src, prev};
    assign dn_base = (OFF_W + 1)'(WORD_W) - {1'b0, sh};

    always_comb begin
        if (cfg.desc) win = cat_dn[dn_base +: WORD_W];
        else          win = cat_up[sh +: WORD_W];
    end

    always_comb begin
        case (cfg.sel)
            SRC_ONES:  s_word = '1;
            SRC_PIXEL: s_word = {WORD_W{src[0]}};
            default:   s_word = win;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
            pend_q <= 1'b0;
        end else if (acc) begin
            hold_q <= src;
            pend_q <= prime;
        end
    end

endmodule

// File: rtl/blit_rop_mask.sv
module blit_rop_mask
    import blit_pkg::*;
(
    input  logic [WORD_W-1:0] s_word,
    input  logic [WORD_W-1:0] dst,
    input  cfg_t              cfg,
    input  logic              first,
    input  logic              last,
    input  logic              align_en,
    output logic [WORD_W-1:0] data,
    output logic [WORD_W-1:0] mask
);

    localparam logic [WORD_W-1:0] ONES     = '1;
    localparam logic [OFF_W-1:0]  LAST_PIX = OFF_W'(WORD_W - 1);

    logic [WORD_W-1:0] r;
    logic [WORD_W-1:0] head_m;
    logic [WORD_W-1:0] tail_m;

    // code bit index {~S,~D}: each function is its own truth table
    for (genvar i = 0; i < WORD_W; i++) begin : g_bit
        assign r[i] = cfg.rop[{~s_word[i], ~dst[i]}];
    end

    always_comb begin
        if (cfg.desc) begin
            head_m = ONES << (LAST_PIX - cfg.start_off);
            tail_m = ONES >> cfg.end_off;
        end else begin
            head_m = ONES >> cfg.start_off;
            tail_m = ONES << (LAST_PIX - cfg.end_off);
        end
        mask = ONES;
        if (align_en && first) mask = mask & head_m;
        if (align_en && last)  mask = mask & tail_m;
    end

    assign data = (r & mask) | (dst & ~mask);

endmodule

// File: rtl/blit_word_path.sv
module blit_word_path
    import blit_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [CFG_DW-1:0] cfg_wdata,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_src,
    input  logic [WORD_W-1:0] in_dst,
    input  logic              in_sol,
    input  logic              in_eol,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_data,
    output logic [WORD_W-1:0] out_mask
);

    cfg_t              cfg_q;
    logic              acc;
    logic [WORD_W-1:0] s_word;
    logic              prime_w;
    logic              first_w;
    logic              align_en_w;
    logic [WORD_W-1:0] data_w;
    logic [WORD_W-1:0] mask_w;

    assign in_ready = ~out_valid | out_ready;
    assign acc      = in_valid & in_ready;

    blit_cfg_regs u_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .cfg   (cfg_q)
    );

    blit_align u_align (
        .clk      (clk),
        .rst      (rst),
        .acc      (acc),
        .cfg      (cfg_q),
        .src      (in_src),
        .sol      (in_sol),
        .s_word   (s_word),
        .prime    (prime_w),
        .first    (first_w),
        .align_en (align_en_w)
    );

    blit_rop_mask u_rop (
        .s_word   (s_word),
        .dst      (in_dst),
        .cfg      (cfg_q),
        .first    (first_w),
        .last     (in_eol),
        .align_en (align_en_w),
        .data     (data_w),
        .mask     (mask_w)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_mask  <= '0;
        end else if (acc) begin
            out_valid <= ~prime_w;
            if (!prime_w) begin
                out_data <= data_w;
                out_mask <= mask_w;
            end
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/blit_word_path_chk.sv
module blit_word_path_chk
    import blit_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_ready,
    input logic [WORD_W-1:0] in_dst,
    input logic              out_valid,
    input logic              out_ready,
    input logic [WORD_W-1:0] out_data,
    input logic [WORD_W-1:0] out_mask,
    input logic              prime,
    input logic              align_en,
    input logic [1:0]        sel,
    input logic [ROP_W-1:0]  rop
);

    assert_hold_stable_R12: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_mask));

    assert_stall_blocks_R12: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |-> !in_ready);

    assert_keep_dst_R11: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready |=> !out_valid || (((out_data ^ $past(in_dst)) & ~out_mask) == '0));

    assert_prime_silent_R7: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready && prime |=> !out_valid);

    assert_plain_full_R13: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready && !align_en |=> out_valid && (out_mask == '1));

    assert_ones_source_R8: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready && sel == 2'b00 && rop == ROP_COPY |=>
            !out_valid || ((out_data & out_mask) == out_mask));

endmodule

bind blit_word_path blit_word_path_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_dst    (in_dst),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_mask  (out_mask),
    .prime     (prime_w),
    .align_en  (align_en_w),
    .sel       (cfg_q.sel),
    .rop       (cfg_q.rop)
);

// File: tb/blit_word_path_tb.sv
module blit_word_path_tb;
    import blit_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] in_src = '0;
    logic [15:0] in_dst = '0;
    logic        in_sol = 1'b0;
    logic        in_eol = 1'b0;
    logic        out_valid;
    logic        out_ready;
    logic [15:0] out_data;
    logic [15:0] out_mask;

    always #(CLK_PERIOD / 2) clk = ~clk;

    blit_word_path u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .in_valid(in_valid), .in_ready(in_ready), .in_src(in_src), .in_dst(in_dst),
        .in_sol(in_sol), .in_eol(in_eol), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_mask(out_mask)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;
    bit bp_en = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // bench mirror of the configuration and row state
    logic [2:0]  m_mode = 3'b111;
    logic [3:0]  m_shift = '0, m_rop = 4'h3, m_soff = '0, m_eoff = '0, m_srcoff = '0;
    logic [1:0]  m_sel = 2'b11;
    logic        m_desc = 1'b0;
    logic [15:0] b_hold = '0;
    logic        b_pend = 1'b0;

    logic [15:0] sb_data[$];
    logic [15:0] sb_mask[$];
    int          sb_due[$];
    string       sb_req[$];

    task automatic check16(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic check_int(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] rop_ref(input logic [3:0] c, input logic [15:0] s, input logic [15:0] d);
        case (c)
            4'h0: return 16'h0000;
            4'h1: return s & d;
            4'h2: return s & ~d;
            4'h3: return s;
            4'h4: return ~s & d;
            4'h5: return d;
            4'h6: return s ^ d;
            4'h7: return s | d;
            4'h8: return ~(s | d);
            4'h9: return ~(s ^ d);
            4'hA: return ~d;
            4'hB: return s | ~d;
            4'hC: return ~s;
            4'hD: return ~s | d;
            4'hE: return ~(s & d);
            default: return 16'hFFFF;
        endcase
    endfunction

    task automatic cfg_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        case (a)
            3'd0: begin m_mode = d[7:5]; m_shift = d[3:0]; end
            3'd1: m_rop = d[3:0];
            3'd2: begin m_sel = d[7:6]; m_desc = d[0]; end
            3'd3: begin m_soff = d[7:4]; m_eoff = d[3:0]; end
            3'd4: m_srcoff = d[3:0];
            default: ;
        endcase
    endtask

    task automatic send(input logic [15:0] src, input logic [15:0] dst, input logic sol, input logic eol, input string req);
        logic al, pr, fst;
        logic [3:0] s;
        logic [15:0] prev, win, sw, mk, hm, tm, exp_d;
        logic [31:0] cat;
        int acc_cyc;
        al   = (m_mode == 3'b100) || (m_mode == 3'b010);
        s    = al ? m_shift : 4'd0;
        pr   = sol && al && (m_desc ? (m_soff > m_srcoff) : (m_soff < m_srcoff));
        prev = sol ? 16'h0 : b_hold;
        fst  = (sol || b_pend) && !pr;
        if (!m_desc) begin
            cat = {prev, src};
            win = 16'(cat >> s);
        end else begin
            cat = {src, prev};
            win = 16'((cat << s) >> 16);
        end
        sw = (m_sel == 2'b00) ? 16'hFFFF : (m_sel == 2'b01) ? {16{src[0]}} : win;
        if (m_desc) begin
            hm = 16'hFFFF << (15 - m_soff);
            tm = 16'hFFFF >> m_eoff;
        end else begin
            hm = 16'hFFFF >> m_soff;
            tm = 16'hFFFF << (15 - m_eoff);
        end
        mk = 16'hFFFF;
        if (al && fst) mk = mk & hm;
        if (al && eol) mk = mk & tm;
        exp_d  = (rop_ref(m_rop, sw, dst) & mk) | (dst & ~mk);
        b_hold = src;
        b_pend = pr;

        @(negedge clk);
        in_valid = 1'b1; in_src = src; in_dst = dst; in_sol = sol; in_eol = eol;
        forever begin
            #1;
            if (in_ready) begin
                acc_cyc = cyc;
                break;
            end
            @(negedge clk);
        end
        if (!pr) begin
            sb_data.push_back(exp_d);
            sb_mask.push_back(mk);
            sb_due.push_back(acc_cyc + 1);
            sb_req.push_back(req);
        end
        @(posedge clk);
        #1 in_valid = 1'b0;
    endtask

    // downstream ready, pseudo-random while back-pressure is enabled
    initial begin
        logic [7:0] lf;
        lf = 8'hA5;
        out_ready = 1'b1;
        forever begin
            @(posedge clk);
            #1;
            lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
            out_ready = bp_en ? lf[0] : 1'b1;
        end
    end

    // monitor: pops expected words, checks due cycle and stall stability
    initial begin
        bit seen, stall;
        logic [15:0] pd, pm;
        seen = 0; stall = 0; pd = '0; pm = '0;
        forever begin
            @(negedge clk);
            if (!rst) begin
                if (stall) begin
                    check16("R12", "stalled data", out_data, pd);
                    check16("R12", "stalled mask", out_mask, pm);
                end
                if (out_valid) begin
                    if (sb_data.size() == 0) begin
                        checks++; errors++;
                        $display("FAIL R7 unexpected word: actual %h expected none", out_data);
                    end else begin
                        if (!seen) begin
                            check_int("R12", "due cycle", cyc, sb_due[0]);
                            seen = 1;
                        end
                        if (out_ready) begin
                            check16(sb_req[0], "data", out_data, sb_data[0]);
                            check16(sb_req[0], "mask", out_mask, sb_mask[0]);
                            void'(sb_data.pop_front()); void'(sb_mask.pop_front());
                            void'(sb_due.pop_front());  void'(sb_req.pop_front());
                            seen = 0;
                        end
                    end
                end
                stall = out_valid && !out_ready;
                pd = out_data; pm = out_mask;
            end
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL R12 watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check16("R2", "out_valid after reset", {15'h0, out_valid}, 16'h0);
        check16("R2", "in_ready after reset", {15'h0, in_ready}, 16'h1);

        // R2: defaults are normal mode and plain copy, even with offsets set
        cfg_write(3'd3, 8'h5A);
        cfg_write(3'd4, 8'h03);
        send(16'h1234, 16'hFFFF, 1, 1, "R2");

        // R1: all sixteen raster codes
        for (int c = 0; c < 16; c++) begin
            cfg_write(3'd1, 8'(c));
            send(16'hC3A5, 16'h0FF0, 1, 1, "R1");
        end
        cfg_write(3'd1, 8'h03);

        // R4 / R9: ascending blit, shift 5, start 7, end 9, no priming
        cfg_write(3'd0, {3'b100, 5'd5});
        cfg_write(3'd2, 8'hC0);
        cfg_write(3'd3, 8'h79);
        cfg_write(3'd4, 8'h02);
        send(16'hA1B2, 16'h0000, 1, 0, "R4");
        send(16'hC3D4, 16'hFFFF, 0, 0, "R4");
        send(16'hE5F6, 16'h5555, 0, 1, "R9");

        // R3: shift field keeps only its low four bits (19 -> 3)
        cfg_write(3'd0, {3'b100, 5'b10011});
        send(16'h8001, 16'h0000, 1, 0, "R3");
        send(16'h7FFE, 16'h0000, 0, 1, "R3");

        // R7: ascending priming read, start 1 below source offset 6, shift 11
        cfg_write(3'd0, {3'b100, 5'd11});
        cfg_write(3'd3, 8'h1E);
        cfg_write(3'd4, 8'h06);
        send(16'h1111, 16'h0F0F, 1, 0, "R7");
        send(16'h2468, 16'h0F0F, 0, 0, "R7");
        send(16'h9ABC, 16'hF0F0, 0, 1, "R7");

        // R5 / R10: descending with priming (start 12 above source 4), shift 8
        cfg_write(3'd0, {3'b100, 5'd8});
        cfg_write(3'd2, 8'hC1);
        cfg_write(3'd3, 8'hC3);
        cfg_write(3'd4, 8'h04);
        send(16'h1357, 16'h0000, 1, 0, "R7");
        send(16'h2468, 16'h0000, 0, 0, "R5");
        send(16'hBEEF, 16'hFFFF, 0, 0, "R5");
        send(16'hCAFE, 16'h0000, 0, 1, "R10");

        // R5: descending without priming (start 12 below source 14), shift 14
        cfg_write(3'd0, {3'b100, 5'd14});
        cfg_write(3'd4, 8'h0E);
        send(16'h00FF, 16'hAAAA, 1, 0, "R5");
        send(16'hF00F, 16'h5555, 0, 1, "R5");

        // R10: single-word rows take the merged mask, both directions
        cfg_write(3'd0, {3'b100, 5'd0});
        cfg_write(3'd4, 8'h0C);
        send(16'hFFFF, 16'h0000, 1, 1, "R10");
        cfg_write(3'd2, 8'hC0);
        cfg_write(3'd3, 8'h3C);
        cfg_write(3'd4, 8'h03);
        send(16'hFFFF, 16'h0000, 1, 1, "R10");

        // R11: raster code all-ones under partial mask leaves destination outside
        cfg_write(3'd1, 8'h0F);
        send(16'h0000, 16'h1248, 1, 1, "R11");
        cfg_write(3'd1, 8'h03);

        // R8: source replacement modes
        cfg_write(3'd2, 8'h00);
        send(16'h0000, 16'h0000, 1, 0, "R8");
        cfg_write(3'd1, 8'h06);
        send(16'h1234, 16'h0F0F, 0, 1, "R8");
        cfg_write(3'd1, 8'h03);
        cfg_write(3'd2, 8'h40);
        send(16'h0001, 16'h0000, 1, 0, "R8");
        send(16'hFFFE, 16'hFFFF, 0, 1, "R8");
        cfg_write(3'd2, 8'h80);
        send(16'hABCD, 16'h0000, 1, 1, "R8");

        // R6: second row starts from a zero previous word
        cfg_write(3'd2, 8'hC0);
        cfg_write(3'd0, {3'b100, 5'd4});
        cfg_write(3'd3, 8'h40);
        cfg_write(3'd4, 8'h00);
        send(16'hFFFF, 16'h0000, 1, 0, "R6");
        send(16'hFFFF, 16'h0000, 0, 1, "R6");
        send(16'hFFFF, 16'h0000, 1, 0, "R6");
        send(16'h0F0F, 16'h0000, 0, 1, "R6");

        // R13: unknown mode code acts as normal, vector mode aligns
        cfg_write(3'd0, {3'b000, 5'd7});
        cfg_write(3'd3, 8'h5A);
        send(16'h4321, 16'h0000, 1, 1, "R13");
        cfg_write(3'd0, {3'b010, 5'd7});
        cfg_write(3'd4, 8'h02);
        send(16'h4321, 16'h0000, 1, 0, "R13");
        send(16'h8765, 16'hFFFF, 0, 1, "R13");

        // R12: back-to-back stream under random back-pressure
        bp_en = 1;
        cfg_write(3'd0, {3'b100, 5'd3});
        cfg_write(3'd1, 8'h06);
        for (int k = 0; k < 12; k++) begin
            send(16'(16'h1F2E * (k + 1)), 16'(16'h3C5A ^ (k * 16'h0111)), k % 4 == 0, k % 4 == 3, "R12");
        end
        bp_en = 0;

        while (sb_data.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule